// File: doc/BRIEF.md
# Scrolling Common-Line Scan Generator

This block paces the row scan of a dot-matrix liquid crystal panel. On every display-clock pulse it names the memory row to fetch for the next common output, and it walks through one frame worth of common slots, whose count is set by three duty-select pins. The first data row of each frame is taken from a start-line register. Rewriting that register scrolls the picture vertically without touching the display memory. The last slot of each frame always fetches a fixed icon row, which does not scroll.

The block also keeps the frame polarity bit, which inverts once per frame so the panel sees no DC bias. It encodes the two-bit drive level for a segment output from one pixel bit, the polarity, the reverse-video mode and the power-save mode. When the full 81-slot duty is selected, it also reports which half of the common drivers the current slot belongs to.

Top module: `scan_com_gen`

## Requirements
- R1: After reset, fetch_addr is 0, fetch_icon is 0, com_idx is 0, frame_pol is 0, and the start-line register holds 0.
- R2: duty_sel selects the number of common slots per frame: 3'b111 gives 81, 3'b110 gives 65, 3'b101 gives 55, 3'b100 gives 49, and 3'b0xx gives 33. com_idx counts the slots from 0. The last slot of a frame is the icon slot.
- R3: Each line_tick taken in a data slot advances com_idx by one and advances fetch_addr by one, modulo 80 (79 is followed by 0). While line_tick is low, all outputs hold.
- R4: The line_tick taken in the icon slot starts a new frame. com_idx returns to 0 and fetch_addr loads the start-line register. A register value of 80 or more is reduced by 80.
- R5: A start_wr pulse updates the start-line register but does not change the fetch sequence until the next frame boundary. A write in the same cycle as the boundary tick is first used at the boundary after that one.
- R6: In the icon slot, fetch_icon is 1 and fetch_addr is 80, whatever the start-line value.
- R7: frame_pol inverts on the boundary tick that leaves the icon slot, and at no other time.
- R8: com_side equals bit 0 of com_idx when duty_sel is 3'b111, and is 0 for any other duty.
- R9: seg_lvl encodes V0=2'b11, V3=2'b01, V2=2'b10, VSS=2'b00. The effective bit is pix_bit XOR rev_mode. Effective bit 1 gives V0 when frame_pol=1 and VSS when frame_pol=0. Effective bit 0 gives V2 when frame_pol=1 and V3 when frame_pol=0.
- R10: When pwr_save is 1, seg_lvl is 2'b00 (VSS) regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_tick | input | 1 | One-cycle display clock pulse; advances the scan |
| duty_sel | input | 3 | Duty ratio select |
| start_wr | input | 1 | Write strobe for the start-line register |
| start_val | input | LINE_W | New start-line value |
| pix_bit | input | 1 | Display data bit for the segment being driven |
| rev_mode | input | 1 | Reverse video: inverts pixel meaning |
| pwr_save | input | 1 | Power save: forces segment level to VSS |
| fetch_addr | output | LINE_W | Memory row to fetch for the current slot |
| fetch_icon | output | 1 | Current slot is the icon slot |
| com_idx | output | LINE_W | Current common slot number |
| com_side | output | 1 | Driver half for the slot in 81-slot duty |
| frame_pol | output | 1 | Frame polarity |
| seg_lvl | output | 2 | Encoded segment drive level |

## Verification
The frame boundary and the start-line write can fall in the same cycle. When they do, the reload must take the old register value while the new one is stored. The bench steps the scan until the model reaches the icon slot, raises start_wr together with the boundary tick, and then expects the old offset in the frame that follows and the new offset (reduced by 80) one frame later. A second collision comes from the polarity flip happening on the same edge as the address reload, which the scoreboard judges on the first slot of every frame.

// File: rtl/scan_pkg.sv
package scan_pkg;

   typedef enum logic [1:0] {
      LVL_VSS = 2'b00,
      LVL_V3  = 2'b01,
      LVL_V2  = 2'b10,
      LVL_V0  = 2'b11
   } seg_lvl_e;

   // number of common slots per frame for a duty select code
   function automatic int unsigned slots_for(input logic [2:0] sel);
      int unsigned n;
      case (sel)
         3'b111:  n = 81;
         3'b110:  n = 65;
         3'b101:  n = 55;
         3'b100:  n = 49;
         default: n = 33;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/scan_duty_dec.sv
module scan_duty_dec #(
   parameter int LINE_W = 7
) (
   input  logic [2:0]        duty_sel,
   output logic [LINE_W-1:0] last_idx,
   output logic              full_mode
);
   import scan_pkg::*;

   always_comb begin
      last_idx  = LINE_W'(slots_for(duty_sel) - 1);
      full_mode = (duty_sel == 3'b111);
   end

endmodule

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
   parameter int LINE_W     = 7,
   parameter int DATA_LINES = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic [LINE_W-1:0] last_idx,
   input  logic              start_wr,
   input  logic [LINE_W-1:0] start_val,
   output logic [LINE_W-1:0] com_idx,
   output logic [LINE_W-1:0] line_addr,
   output logic              at_icon,
   output logic              frame_pol
);
   localparam logic [LINE_W-1:0] LINES_V   = LINE_W'(DATA_LINES);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(DATA_LINES - 1);
   localparam bool_single_sub = ((2 ** LINE_W) <= 2 * DATA_LINES);

   logic [LINE_W-1:0] start_reg;
   logic [LINE_W-1:0] start_eff;
   logic [LINE_W-1:0] line_nxt;

   // fold the register into the addressable range
   generate
      if (bool_single_sub) begin : g_fold_sub
         assign start_eff = (start_reg >= LINES_V) ? start_reg - LINES_V : start_reg;
      end else begin : g_fold_mod
         assign start_eff = start_reg % LINES_V;
      end
   endgenerate

   assign at_icon  = (com_idx >= last_idx);
   assign line_nxt = (line_addr == LAST_LINE) ? '0 : line_addr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_reg <= '0;
      end else if (start_wr) begin
         start_reg <= start_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         com_idx   <= '0;
         line_addr <= '0;
         frame_pol <= 1'b0;
      end else if (line_tick) begin
         if (at_icon) begin
            com_idx   <= '0;
            line_addr <= start_eff;
            frame_pol <= ~frame_pol;
         end else begin
            com_idx   <= com_idx + 1'b1;
            line_addr <= line_nxt;
         end
      end
   end

endmodule

// File: rtl/scan_seg_enc.sv
module scan_seg_enc (
   input  logic       pix_bit,
   input  logic       rev_mode,
   input  logic       frame_pol,
   input  logic       pwr_save,
   output logic [1:0] seg_lvl
);
   import scan_pkg::*;

   seg_lvl_e lvl;
   logic     eff;

   always_comb begin
      eff = pix_bit ^ rev_mode;
      if (pwr_save)     lvl = LVL_VSS;
      else if (eff)     lvl = frame_pol ? LVL_V0 : LVL_VSS;
      else              lvl = frame_pol ? LVL_V2 : LVL_V3;
      seg_lvl = lvl;
   end

endmodule

// File: rtl/scan_com_gen.sv
module scan_com_gen #(
   parameter int LINE_W     = 7,
   parameter int DATA_LINES = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic [2:0]        duty_sel,
   input  logic              start_wr,
   input  logic [LINE_W-1:0] start_val,
   input  logic              pix_bit,
   input  logic              rev_mode,
   input  logic              pwr_save,
   output logic [LINE_W-1:0] fetch_addr,
   output logic              fetch_icon,
   output logic [LINE_W-1:0] com_idx,
   output logic              com_side,
   output logic              frame_pol,
   output logic [1:0]        seg_lvl
);
   localparam logic [LINE_W-1:0] ICON_ROW = LINE_W'(DATA_LINES);

   generate
      if (LINE_W < 7) begin : g_bad_width
         $error("scan_com_gen: LINE_W must be at least 7");
      end
      if (DATA_LINES < 80 || DATA_LINES >= (2 ** LINE_W)) begin : g_bad_lines
         $error("scan_com_gen: DATA_LINES must cover 80 rows and leave room for the icon row");
      end
   endgenerate

   logic [LINE_W-1:0] last_idx;
   logic              full_mode;
   logic [LINE_W-1:0] line_addr;
   logic              at_icon;

   scan_duty_dec #(.LINE_W(LINE_W)) u_duty (
      .duty_sel  (duty_sel),
      .last_idx  (last_idx),
      .full_mode (full_mode)
   );

   scan_line_ctr #(.LINE_W(LINE_W), .DATA_LINES(DATA_LINES)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_tick (line_tick),
      .last_idx  (last_idx),
      .start_wr  (start_wr),
      .start_val (start_val),
      .com_idx   (com_idx),
      .line_addr (line_addr),
      .at_icon   (at_icon),
      .frame_pol (frame_pol)
   );

   scan_seg_enc u_seg (
      .pix_bit   (pix_bit),
      .rev_mode  (rev_mode),
      .frame_pol (frame_pol),
      .pwr_save  (pwr_save),
      .seg_lvl   (seg_lvl)
   );

   assign fetch_icon = at_icon;
   assign fetch_addr = at_icon ? ICON_ROW : line_addr;
   assign com_side   = full_mode & com_idx[0];

endmodule

// File: rtl/scan_com_gen_chk.sv
module scan_com_gen_chk #(
   parameter int LINE_W     = 7,
   parameter int DATA_LINES = 80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_tick,
   input logic [2:0]        duty_sel,
   input logic              pwr_save,
   input logic [LINE_W-1:0] fetch_addr,
   input logic              fetch_icon,
   input logic [LINE_W-1:0] com_idx,
   input logic              com_side,
   input logic              frame_pol,
   input logic [1:0]        seg_lvl
);
   localparam logic [LINE_W-1:0] ICON_ROW  = LINE_W'(DATA_LINES);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(DATA_LINES - 1);

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && !fetch_icon |=> fetch_icon ||
         fetch_addr == (($past(fetch_addr) == LAST_LINE) ? '0 : $past(fetch_addr) + 1'b1)); // R3
   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && !fetch_icon |=> com_idx == $past(com_idx) + 1'b1); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick ##1 $stable(duty_sel) |-> $stable(fetch_addr) && $stable(com_idx)); // R3
   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && fetch_icon |=> com_idx == '0); // R4
   AST_ICON_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_icon |-> fetch_addr == ICON_ROW); // R6
   AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      line_tick && fetch_icon |=> frame_pol != $past(frame_pol)); // R7
   AST_POL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_tick && fetch_icon) |=> $stable(frame_pol)); // R7
   AST_SIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      duty_sel != 3'b111 |-> !com_side); // R8
   AST_SAVE_VSS: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save |-> seg_lvl == 2'b00); // R10

endmodule

bind scan_com_gen scan_com_gen_chk #(.LINE_W(LINE_W), .DATA_LINES(DATA_LINES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_tick  (line_tick),
   .duty_sel   (duty_sel),
   .pwr_save   (pwr_save),
   .fetch_addr (fetch_addr),
   .fetch_icon (fetch_icon),
   .com_idx    (com_idx),
   .com_side   (com_side),
   .frame_pol  (frame_pol),
   .seg_lvl    (seg_lvl)
);

// File: tb/tb_scan_com_gen.sv
module tb_scan_com_gen;
   localparam int LW = 7;
   localparam int DL = 80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_tick = 1'b0;
   logic [2:0]    duty_sel = 3'b000;
   logic          start_wr = 1'b0;
   logic [LW-1:0] start_val = '0;
   logic          pix_bit = 1'b0;
   logic          rev_mode = 1'b0;
   logic          pwr_save = 1'b0;
   logic [LW-1:0] fetch_addr;
   logic          fetch_icon;
   logic [LW-1:0] com_idx;
   logic          com_side;
   logic          frame_pol;
   logic [1:0]    seg_lvl;

   always #2.5 clk = ~clk;

   scan_com_gen #(.LINE_W(LW), .DATA_LINES(DL)) dut (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .duty_sel(duty_sel),
      .start_wr(start_wr), .start_val(start_val), .pix_bit(pix_bit),
      .rev_mode(rev_mode), .pwr_save(pwr_save), .fetch_addr(fetch_addr),
      .fetch_icon(fetch_icon), .com_idx(com_idx), .com_side(com_side),
      .frame_pol(frame_pol), .seg_lvl(seg_lvl)
   );

   typedef struct {
      string      req;
      int         addr;
      bit         icon;
      int         idx;
      bit         side;
      bit         pol;
      int         lvl;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   // reference model state
   int m_idx = 0, m_line = 0, m_start = 0;
   bit m_pol = 0;

   function automatic int slots(input logic [2:0] s);
      if (s == 3'b111) return 81;
      if (s == 3'b110) return 65;
      if (s == 3'b101) return 55;
      if (s == 3'b100) return 49;
      return 33;
   endfunction

   function automatic int lvl_of(input bit p, input bit r, input bit fr, input bit ps);
      if (ps) return 0;
      if (p ^ r) return fr ? 3 : 0;
      return fr ? 2 : 1;
   endfunction

   task automatic expect_now(input string req);
      exp_t e;
      bit   ic;
      ic     = (m_idx >= slots(duty_sel) - 1);
      e.req  = req;
      e.icon = ic;
      e.addr = ic ? DL : m_line;
      e.idx  = m_idx;
      e.side = (duty_sel == 3'b111) ? m_idx[0] : 1'b0;
      e.pol  = m_pol;
      e.lvl  = lvl_of(pix_bit, rev_mode, m_pol, pwr_save);
      q.push_back(e);
   endtask

   task automatic step(input bit tick, input string req);
      line_tick = tick;
      @(posedge clk);
      if (tick) begin
         if (m_idx >= slots(duty_sel) - 1) begin
            m_idx  = 0;
            m_line = (m_start >= DL) ? m_start - DL : m_start;
            m_pol  = ~m_pol;
         end else begin
            m_idx  = m_idx + 1;
            m_line = (m_line == DL - 1) ? 0 : m_line + 1;
         end
      end
      if (start_wr) m_start = start_val;
      expect_now(req);
      @(negedge clk);
      #1;
      line_tick = 1'b0;
      start_wr  = 1'b0;
   endtask

   task automatic cmp(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: compare design outputs with queued expectations
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.req, "fetch_addr", int'(fetch_addr), e.addr);
            cmp(e.req, "fetch_icon", int'(fetch_icon), int'(e.icon));
            cmp(e.req, "com_idx", int'(com_idx), e.idx);
            cmp(e.req, "com_side", int'(com_side), int'(e.side));
            cmp(e.req, "frame_pol", int'(frame_pol), int'(e.pol));
            cmp(e.req, "seg_lvl", int'(seg_lvl), e.lvl);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      step(0, "R1 reset");

      // R2 R6 R7: one full 33-slot frame and the boundary
      for (int i = 0; i < 33; i++) step(1, "R2 R6 R7 duty 33");

      // R3 hold while no tick
      for (int i = 0; i < 3; i++) step(0, "R3 hold");

      // R5 mid-frame write, then R4 reload and wrap 79->0
      for (int i = 0; i < 4; i++) step(1, "R3 advance");
      start_val = 7'd75;
      start_wr  = 1'b1;
      step(1, "R5 mid-frame write");
      for (int i = 0; i < 40; i++) step(1, "R4 R5 reload and wrap");

      // R5 write coinciding with the boundary tick; R4 reduction of 100
      while (m_idx != 32) step(1, "R3 approach boundary");
      start_val = 7'd100;
      start_wr  = 1'b1;
      step(1, "R5 write on boundary");
      for (int i = 0; i < 33; i++) step(1, "R4 R5 old offset frame");
      for (int i = 0; i < 5; i++) step(1, "R4 reduced offset");

      // R8 full duty with side reporting
      while (m_idx != 0) step(1, "R2 finish frame");
      duty_sel = 3'b111;
      for (int i = 0; i < 83; i++) step(1, "R2 R6 R8 duty 81");

      // other duties
      while (m_idx != 0) step(1, "R2 finish frame");
      duty_sel = 3'b110;
      for (int i = 0; i < 66; i++) step(1, "R2 R8 duty 65");
      while (m_idx != 0) step(1, "R2 finish frame");
      duty_sel = 3'b101;
      for (int i = 0; i < 56; i++) step(1, "R2 duty 55");
      while (m_idx != 0) step(1, "R2 finish frame");
      duty_sel = 3'b100;
      for (int i = 0; i < 50; i++) step(1, "R2 duty 49");

      // R9 R10 segment levels in both polarities
      for (int f = 0; f < 2; f++) begin
         for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 2; r++) begin
               for (int s = 0; s < 2; s++) begin
                  pix_bit  = p[0];
                  rev_mode = r[0];
                  pwr_save = s[0];
                  step(0, s ? "R10 power save" : "R9 level encode");
               end
            end
         end
         pwr_save = 1'b0;
         while (m_idx != 0 || f == 0) begin
            step(1, "R7 next frame");
            if (m_idx == 0) break;
         end
      end

      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule